// File: doc/BRIEF.md
# Supervisor Counter Inhibit Alias

This block gives supervisor software a masked window onto the machine-level counter-inhibit register, so that a kernel or hypervisor can start and stop the counters machine mode has handed to it without a round trip through machine mode. Only one physical register exists. The supervisor view is computed on every access from that register and the current delegation mask. Bits of delegated counters can be seen and changed. All other bits read as zero and cannot be written.

The block also decides the trap outcome for three CSR targets: the machine inhibit register, its supervisor alias, and the counter-overflow status register. The outcome depends on the delegation-enable bit, the privilege mode, the virtualization flag and whether a hypervisor is implemented. A request is presented for one cycle with `acc_valid`. One cycle later `resp_valid` rises with the read data (the value before any write), the trap flags and the updated inhibit register. The counters that obey the inhibit bits are outside this block.

Top module: `cnt_inhibit_alias`

## Requirements
- R1: A read of the supervisor view (target code 1) that does not trap returns machine inhibit bit i where `deleg_mask[i]`=1, and 0 in every other bit.
- R2: A write to the supervisor view that does not trap loads `acc_wdata[i]` into machine inhibit bit i where `deleg_mask[i]`=1. Every undelegated bit keeps its value.
- R3: With `deleg_en`=0, any access to the supervisor view raises illegal-instruction in every mode and changes nothing.
- R4: With `deleg_en`=1, an access to the supervisor view while virtualized raises virtual-instruction and changes nothing. Virtualized means `virt`=1, `hyp_present`=1 and privilege S (1) or U (0). At privilege M (3), `virt` is ignored.
- R5: A virtualized access to the overflow-status register (target code 2) raises virtual-instruction when `deleg_en`=1 and raises no trap when `deleg_en`=0. A non-virtualized access from S or M raises no trap. Overflow-status reads return 0 from this block.
- R6: The machine inhibit register (target code 0) is fully readable and writable from privilege M, whatever the mask and `deleg_en`. The same access from S or U raises illegal-instruction.
- R7: A non-virtualized access from U to the supervisor view or to overflow status raises illegal-instruction. Target code 3 raises illegal-instruction from every mode.
- R8: A change of `deleg_mask` applies to the very next access, with no extra cycle or storage update.
- R9: A synchronous reset (`rst`=1 at a clock edge) clears the inhibit register, the read data, both trap flags and `resp_valid`.
- R10: `resp_valid` is 1 exactly one cycle after a cycle with `acc_valid`=1, and 0 otherwise. A trapped access returns read data 0 and writes nothing.
- R11: `trap_illegal` and `trap_virtual` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_target | input | 2 | 0 machine inhibit, 1 supervisor view, 2 overflow status, 3 reserved |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 2 | Privilege: 0 U, 1 S, 3 M |
| acc_virt | input | 1 | Hart is in a virtualized mode |
| hyp_present | input | 1 | Hypervisor support implemented |
| deleg_en | input | 1 | Counter delegation enabled |
| deleg_mask | input | 32 | Bit i = counter i delegated to supervisor |
| resp_valid | output | 1 | Response for the previous cycle's request |
| rd_data | output | 32 | Read data (value before the write) |
| trap_illegal | output | 1 | Illegal-instruction outcome |
| trap_virtual | output | 1 | Virtual-instruction outcome |
| minhibit | output | 32 | Machine counter-inhibit register |

## Verification
The bench first writes a pattern with distinct halves through the machine view. It then reads and writes the alias under masks that overlap the set bits only in part, so a design that wrote undelegated bits, or that leaked them into the read, shows a wrong word. Back-to-back accesses use different masks to catch a design that latched the mask. The bench drives `virt`=1 at privilege M and also with `deleg_en`=0 on overflow status, which separates the illegal, virtual and no-trap outcomes. A design that ranked them in the wrong order would give the wrong flag. Finally, reset is applied in the middle of the run and must leave a cleared register.

// File: rtl/cnt_inhibit_pkg.sv
package cnt_inhibit_pkg;
  typedef enum logic [1:0] {
    TGT_MINH = 2'd0,
    TGT_SINH = 2'd1,
    TGT_OVF  = 2'd2,
    TGT_RSVD = 2'd3
  } tgt_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    TRAP_NONE    = 2'd0,
    TRAP_ILLEGAL = 2'd1,
    TRAP_VIRTUAL = 2'd2
  } trap_e;
endpackage

// File: rtl/cnt_inhibit_access.sv
module cnt_inhibit_access
  import cnt_inhibit_pkg::*;
(
  input  tgt_e       target,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       hyp_present,
  input  logic       deleg_en,
  output trap_e      trap
);
  logic in_guest;
  assign in_guest = virt & hyp_present & (priv != PRIV_M);

  always_comb begin
    trap = TRAP_NONE;
    unique case (target)
      TGT_MINH: if (priv != PRIV_M) trap = TRAP_ILLEGAL;
      TGT_SINH: begin
        if (!deleg_en)            trap = TRAP_ILLEGAL;
        else if (in_guest)        trap = TRAP_VIRTUAL;
        else if (priv == PRIV_U)  trap = TRAP_ILLEGAL;
      end
      TGT_OVF: begin
        if (in_guest) begin
          if (deleg_en) trap = TRAP_VIRTUAL;
        end else if (priv == PRIV_U) begin
          trap = TRAP_ILLEGAL;
        end
      end
      default: trap = TRAP_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/cnt_inhibit_view.sv
module cnt_inhibit_view
  import cnt_inhibit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] wdata,
  input  tgt_e             target,
  output logic [CNT_W-1:0] rd_val,
  output logic [CNT_W-1:0] wr_val
);
  logic [CNT_W-1:0] s_rd, s_wr;

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    assign s_rd[i] = cur[i] & mask[i];
    assign s_wr[i] = mask[i] ? wdata[i] : cur[i];
  end

  always_comb begin
    rd_val = '0;
    wr_val = cur;
    unique case (target)
      TGT_MINH: begin rd_val = cur;  wr_val = wdata; end
      TGT_SINH: begin rd_val = s_rd; wr_val = s_wr;  end
      default:  begin rd_val = '0;   wr_val = cur;   end
    endcase
  end
endmodule

// File: rtl/cnt_inhibit_alias.sv
module cnt_inhibit_alias
  import cnt_inhibit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_target,
  input  logic [CNT_W-1:0] acc_wdata,
  input  logic [1:0]       acc_priv,
  input  logic             acc_virt,
  input  logic             hyp_present,
  input  logic             deleg_en,
  input  logic [CNT_W-1:0] deleg_mask,
  output logic             resp_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             trap_illegal,
  output logic             trap_virtual,
  output logic [CNT_W-1:0] minhibit
);
  tgt_e             tgt;
  trap_e            trap;
  logic [CNT_W-1:0] rd_val, wr_val;
  logic             ok;

  assign tgt = tgt_e'(acc_target);
  assign ok  = (trap == TRAP_NONE);

  cnt_inhibit_access u_access (
    .target      (tgt),
    .priv        (acc_priv),
    .virt        (acc_virt),
    .hyp_present (hyp_present),
    .deleg_en    (deleg_en),
    .trap        (trap)
  );

  cnt_inhibit_view #(.CNT_W(CNT_W)) u_view (
    .cur    (minhibit),
    .mask   (deleg_mask),
    .wdata  (acc_wdata),
    .target (tgt),
    .rd_val (rd_val),
    .wr_val (wr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      minhibit     <= '0;
      rd_data      <= '0;
      resp_valid   <= 1'b0;
      trap_illegal <= 1'b0;
      trap_virtual <= 1'b0;
    end else begin
      resp_valid   <= acc_valid;
      trap_illegal <= acc_valid && (trap == TRAP_ILLEGAL);
      trap_virtual <= acc_valid && (trap == TRAP_VIRTUAL);
      rd_data      <= (acc_valid && ok) ? rd_val : '0;
      if (acc_valid && acc_write && ok) minhibit <= wr_val;
    end
  end
endmodule

// File: rtl/cnt_inhibit_alias_chk.sv
module cnt_inhibit_alias_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [1:0]       acc_target,
  input logic [1:0]       acc_priv,
  input logic             acc_virt,
  input logic             hyp_present,
  input logic             deleg_en,
  input logic [CNT_W-1:0] deleg_mask,
  input logic             resp_valid,
  input logic [CNT_W-1:0] rd_data,
  input logic             trap_illegal,
  input logic             trap_virtual,
  input logic [CNT_W-1:0] minhibit
);
  a_r1_masked_read: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_target == 2'd1 |=> (rd_data & ~$past(deleg_mask)) == '0);

  a_r2_undelegated_kept: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_write && acc_target == 2'd1
    |=> ((minhibit ^ $past(minhibit)) & ~$past(deleg_mask)) == '0);

  a_r3_no_deleg_illegal: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_target == 2'd1 && !deleg_en |=> trap_illegal);

  a_r4_guest_virtual: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_target == 2'd1 && deleg_en && acc_virt && hyp_present
    && acc_priv != 2'd3 |=> trap_virtual);

  a_r5_ovf_guest_virtual: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_target == 2'd2 && deleg_en && acc_virt && hyp_present
    && acc_priv != 2'd3 |=> trap_virtual);

  a_r10_resp_timing: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> resp_valid);

  a_r10_trap_no_write: assert property (@(posedge clk) disable iff (rst)
    resp_valid && (trap_illegal || trap_virtual)
    |-> minhibit == $past(minhibit) && rd_data == '0);

  a_r11_one_trap: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_illegal, trap_virtual}));

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> minhibit == '0 && !resp_valid);
endmodule

bind cnt_inhibit_alias cnt_inhibit_alias_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_target   (acc_target),
  .acc_priv     (acc_priv),
  .acc_virt     (acc_virt),
  .hyp_present  (hyp_present),
  .deleg_en     (deleg_en),
  .deleg_mask   (deleg_mask),
  .resp_valid   (resp_valid),
  .rd_data      (rd_data),
  .trap_illegal (trap_illegal),
  .trap_virtual (trap_virtual),
  .minhibit     (minhibit)
);

// File: tb/cnt_inhibit_alias_test.sv
module cnt_inhibit_alias_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_target = 2'd0, acc_priv = 2'd3;
  logic [31:0] acc_wdata = '0, deleg_mask = '0;
  logic        acc_virt = 1'b0, hyp_present = 1'b0, deleg_en = 1'b0;
  logic        resp_valid, trap_illegal, trap_virtual;
  logic [31:0] rd_data, minhibit;
  int          checks = 0, failures = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  cnt_inhibit_alias uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_target(acc_target), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
    .acc_virt(acc_virt), .hyp_present(hyp_present), .deleg_en(deleg_en),
    .deleg_mask(deleg_mask), .resp_valid(resp_valid), .rd_data(rd_data),
    .trap_illegal(trap_illegal), .trap_virtual(trap_virtual), .minhibit(minhibit)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  tgt;
    logic [1:0]  prv;
    logic        vt;
    logic        hy;
    logic        de;
    logic [31:0] msk;
    logic [31:0] wd;
    logic [31:0] erd;
    logic        eil;
    logic        evt;
    logic [31:0] emh;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R6: machine write from M, mask and enable ignored
    '{1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0, 32'hA5A5_F00F, 32'h0, 1'b0, 1'b0, 32'hA5A5_F00F, 4'd6},
    // R1: masked read
    '{1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_00FF, 32'h0, 32'h0000_000F, 1'b0, 1'b0, 32'hA5A5_F00F, 4'd1},
    // R2: masked write
    '{1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_FF00, 32'hFFFF_0000, 32'h0000_F000, 1'b0, 1'b0, 32'hA5A5_000F, 4'd2},
    // R8: new mask applies at once
    '{1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'hA5A5_000F, 1'b0, 1'b0, 32'hA5A5_000F, 4'd8},
    // R3: delegation off
    '{1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b0, 32'hA5A5_000F, 4'd3},
    // R4: guest write to alias
    '{1'b1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b1, 32'hA5A5_000F, 4'd4},
    // R5: guest overflow access, delegation on
    '{1'b0, 2'd2, 2'd1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b1, 32'hA5A5_000F, 4'd5},
    // R5: guest overflow access, delegation off
    '{1'b0, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b0, 32'hA5A5_000F, 4'd5},
    // R5: S overflow access
    '{1'b0, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b0, 32'hA5A5_000F, 4'd5},
    // R7: U read of alias
    '{1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b0, 32'hA5A5_000F, 4'd7},
    // R6: S access to machine register
    '{1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b0, 32'hA5A5_000F, 4'd6},
    // R7: U overflow access
    '{1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b0, 32'hA5A5_000F, 4'd7},
    // R4: virt ignored at M, masked write
    '{1'b1, 2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 32'h0000_0003, 32'h0, 32'h0000_0003, 1'b0, 1'b0, 32'hA5A5_000C, 4'd4},
    // R7: reserved target
    '{1'b0, 2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b0, 32'hA5A5_000C, 4'd7}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input vec_t v);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = v.wr; acc_target = v.tgt; acc_priv = v.prv;
    acc_virt = v.vt; hyp_present = v.hy; deleg_en = v.de;
    deleg_mask = v.msk; acc_wdata = v.wd;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9", "minhibit", minhibit, 32'h0);
    check("R9", "resp_valid", {31'b0, resp_valid}, 32'h0);
    check("R9", "traps", {30'b0, trap_illegal, trap_virtual}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[k].rq);
      access(VEC[k]);
      check("R10", "resp_valid", {31'b0, resp_valid}, 32'h1);
      check(tag, "rd_data", rd_data, VEC[k].erd);
      check(tag, "trap_illegal", {31'b0, trap_illegal}, {31'b0, VEC[k].eil});
      check(tag, "trap_virtual", {31'b0, trap_virtual}, {31'b0, VEC[k].evt});
      check(tag, "minhibit", minhibit, VEC[k].emh);
      // R11: exclusive trap flags
      check("R11", "both traps", {31'b0, trap_illegal & trap_virtual}, 32'h0);
    end

    // R10: idle cycle gives no response
    @(negedge clk);
    check("R10", "idle resp_valid", {31'b0, resp_valid}, 32'h0);

    // R9: reset in mid-run clears the register
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", "minhibit after reset", minhibit, 32'h0);
    check("R9", "rd_data after reset", rd_data, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule